// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits in front of a processor's exception entry logic. Every cycle it collects the pending exception requests and picks one winner by a fixed ranking. It then issues a single-cycle take strobe together with that winner's vector address and a one-hot cause code. The sources are:

- a reset request
- a data abort and a prefetch abort
- a supervisor-call flag and an undefined-instruction flag
- two asynchronous interrupt lines, one fast and one normal, each with its own mask bit

The two interrupt lines are resynchronised in a two-flop chain before they reach arbitration. Synchronous sources enter the pipeline directly. All requests are level signals that the requester holds until its handler clears them. Once the unit strobes, it stays quiet until the core pulses the acknowledge input. A latency meter reports how many cycles passed between the first unmasked raw request seen while the unit was idle and the strobe that followed.

Top module: `trap_select_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request pending, `take_o`, `cause_o`, `conflict_o`, `vector_o` and `latency_o` are all zero.
- R2: The vector offsets are reset 0x00, undefined instruction 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18 and fast interrupt 0x1C. At every strobe, `vector_o` equals `VEC_BASE` plus the offset of the winning source.
- R3: `vector_o` never shows `VEC_BASE` + 0x14 when `take_o` is high.
- R4: The ranking, highest first, is reset, data abort, fast interrupt, normal interrupt, prefetch abort, and then undefined instruction or supervisor call. `cause_o` is one-hot at each strobe, with bit 0 reset, bit 1 data abort, bit 2 fast interrupt, bit 3 normal interrupt, bit 4 prefetch abort, bit 5 supervisor call and bit 6 undefined instruction.
- R5: When the fast and normal interrupt lines are both pending and unmasked, the fast interrupt is taken.
- R6: If supervisor call and undefined instruction are both pending and their shared level wins, the undefined instruction is taken and `conflict_o` pulses high with the strobe. `conflict_o` is never high without that strobe.
- R7: A fast or normal interrupt line whose mask bit is 1 takes no part in arbitration and produces no strobe. Reset and the two aborts have no mask.
- R8: On an idle unit, `take_o` rises 5 clock edges after an interrupt line rises, and 3 clock edges after a synchronous request is presented.
- R9: `take_o` is high for exactly one cycle. No further strobe occurs until `ack_i` has been sampled high. A request that is still pending is taken on the fourth rising edge counted from the edge that samples `ack_i`.
- R10: At each strobe, `latency_o` loads the number of edges between the first unmasked raw request seen while idle and that strobe. The count is 5 for an interrupt and 3 for a synchronous source on an idle unit. The value holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reset_req_i | input | 1 | Reset exception request |
| dabort_i | input | 1 | Data abort request |
| pabort_i | input | 1 | Prefetch abort request |
| fast_int_i | input | 1 | Fast interrupt line, asynchronous |
| norm_int_i | input | 1 | Normal interrupt line, asynchronous |
| svc_i | input | 1 | Supervisor-call flag |
| undef_i | input | 1 | Undefined-instruction flag |
| fast_mask_i | input | 1 | 1 masks the fast interrupt line |
| norm_mask_i | input | 1 | 1 masks the normal interrupt line |
| ack_i | input | 1 | Exception entry acknowledge, re-arms the unit |
| take_o | output | 1 | Single-cycle take-exception strobe |
| vector_o | output | VEC_W | Vector address of the last taken exception |
| cause_o | output | 7 | One-hot cause of the last taken exception |
| conflict_o | output | 1 | Supervisor call and undefined instruction seen together |
| latency_o | output | LAT_W | Request-to-strobe cycle count of the last strobe |

## Verification
The interesting collision is an asynchronous interrupt and a lower-ranked synchronous source arriving in the same cycle. The bench raises the fast interrupt and a prefetch abort on the same clock. The abort is still expected to win first, after 3 edges, because the interrupt is still inside its synchronizer. Once the abort is acknowledged, the fast interrupt is expected 4 edges after the acknowledge, with vector 0x1C and a latency of 3. A second directed case keeps a data abort held without acknowledging it, and judges that no strobe appears until `ack_i` is given.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int unsigned NSRC  = 7;
  localparam int unsigned C_RST  = 0;
  localparam int unsigned C_DABT = 1;
  localparam int unsigned C_FAST = 2;
  localparam int unsigned C_NORM = 3;
  localparam int unsigned C_PABT = 4;
  localparam int unsigned C_SVC  = 5;
  localparam int unsigned C_UND  = 6;

  localparam logic [7:0] RSVD_OFF = 8'h14;

  typedef logic [NSRC-1:0] src_vec_t;

  // Source index held at a given rank, rank 0 being the strongest.
  // Undefined instruction is placed ahead of supervisor call to settle
  // the case where both share the lowest level.
  function automatic int unsigned rank_src(input int unsigned rank);
    case (rank)
      0:       return C_RST;
      1:       return C_DABT;
      2:       return C_FAST;
      3:       return C_NORM;
      4:       return C_PABT;
      5:       return C_UND;
      default: return C_SVC;
    endcase
  endfunction

  // Vector offset of a source.
  function automatic logic [7:0] src_offset(input int unsigned src);
    case (src)
      C_RST:   return 8'h00;
      C_UND:   return 8'h04;
      C_SVC:   return 8'h08;
      C_PABT:  return 8'h0C;
      C_DABT:  return 8'h10;
      C_NORM:  return 8'h18;
      default: return 8'h1C;
    endcase
  endfunction

endpackage

// File: rtl/trap_sync.sv
module trap_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      logic [STAGES-1:0][WIDTH-1:0] chain_d;

      always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
          chain_d[i] = chain_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= chain_d;
        end
      end

      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/trap_prio.sv
module trap_prio
  import trap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush_i,
  input  src_vec_t pend_i,
  output src_vec_t win_o,
  output logic     clash_o
);

  src_vec_t pend_q, pend_d;
  src_vec_t win_q, win_d, win_nx;
  logic     clash_q, clash_d, clash_nx;
  logic     found;
  logic     cap_en;

  // Stage 2 combinational pick from the captured pending set.
  always_comb begin
    win_nx = '0;
    found  = 1'b0;
    for (int r = 0; r < NSRC; r++) begin
      if (!found && pend_q[rank_src(r)]) begin
        win_nx[rank_src(r)] = 1'b1;
        found               = 1'b1;
      end
    end
    clash_nx = win_nx[C_UND] & pend_q[C_SVC];
  end

  assign cap_en = 1'b1;

  always_comb begin
    pend_d  = flush_i ? '0   : pend_i;
    win_d   = flush_i ? '0   : win_nx;
    clash_d = flush_i ? 1'b0 : clash_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      win_q   <= '0;
      clash_q <= 1'b0;
    end else if (cap_en) begin
      pend_q  <= pend_d;
      win_q   <= win_d;
      clash_q <= clash_d;
    end
  end

  assign win_o   = win_q;
  assign clash_o = clash_q;

endmodule

// File: rtl/trap_issue.sv
module trap_issue
  import trap_pkg::*;
#(
  parameter int unsigned           VEC_W    = 32,
  parameter logic [VEC_W-1:0]      VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         win_i,
  input  logic             clash_i,
  input  logic             ack_i,
  output logic             take_nx_o,
  output logic             busy_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vector_o,
  output src_vec_t         cause_o,
  output logic             conflict_o
);

  logic             take_q, take_d;
  logic             busy_q, busy_d;
  logic             conf_q, conf_d;
  logic             load_en;
  logic [7:0]       off_nx;
  logic [VEC_W-1:0] vec_q, vec_nx;
  src_vec_t         cause_q;

  always_comb begin
    off_nx = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (win_i[s]) begin
        off_nx = off_nx | src_offset(s);
      end
    end
    vec_nx = VEC_BASE + VEC_W'(off_nx);
  end

  always_comb begin
    take_d  = (|win_i) & ~busy_q;
    busy_d  = take_d | (busy_q & ~ack_i);
    conf_d  = take_d & clash_i;
    load_en = take_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      busy_q <= 1'b0;
      conf_q <= 1'b0;
    end else begin
      take_q <= take_d;
      busy_q <= busy_d;
      conf_q <= conf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      cause_q <= '0;
    end else if (load_en) begin
      vec_q   <= vec_nx;
      cause_q <= win_i;
    end
  end

  assign take_nx_o  = take_d;
  assign busy_o     = busy_q;
  assign take_o     = take_q;
  assign vector_o   = vec_q;
  assign cause_o    = cause_q;
  assign conflict_o = conf_q;

endmodule

// File: rtl/trap_lat_meter.sv
module trap_lat_meter #(
  parameter int unsigned LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             active_i,
  input  logic             take_i,
  output logic [LAT_W-1:0] lat_o
);

  localparam logic [LAT_W-1:0] CNT_MAX = '1;

  logic [LAT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [LAT_W-1:0] lat_q;
  logic             lat_en;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    if (idle_i && active_i) begin
      cnt_d = cnt_inc;
    end else begin
      cnt_d = '0;
    end
    lat_en = take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= cnt_inc;
    end
  end

  assign lat_o = lat_q;

endmodule

// File: rtl/trap_select_unit.sv
module trap_select_unit
  import trap_pkg::*;
#(
  parameter int unsigned      VEC_W       = 32,
  parameter logic [VEC_W-1:0] VEC_BASE    = '0,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      RST_STAGES  = 2,
  parameter int unsigned      LAT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req_i,
  input  logic             dabort_i,
  input  logic             pabort_i,
  input  logic             fast_int_i,
  input  logic             norm_int_i,
  input  logic             svc_i,
  input  logic             undef_i,
  input  logic             fast_mask_i,
  input  logic             norm_mask_i,
  input  logic             ack_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [NSRC-1:0]  cause_o,
  output logic             conflict_o,
  output logic [LAT_W-1:0] latency_o
);

  logic       rst_sync_n;
  logic [1:0] int_raw, int_sync;
  src_vec_t   pend;
  src_vec_t   win;
  logic       clash;
  logic       busy;
  logic       take_nx;
  logic       active_raw;

  trap_sync #(.STAGES(RST_STAGES), .WIDTH(1)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  assign int_raw = {norm_int_i, fast_int_i};

  trap_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_int_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (int_raw),
    .q_o   (int_sync)
  );

  always_comb begin
    pend         = '0;
    pend[C_RST]  = reset_req_i;
    pend[C_DABT] = dabort_i;
    pend[C_FAST] = int_sync[0] & ~fast_mask_i;
    pend[C_NORM] = int_sync[1] & ~norm_mask_i;
    pend[C_PABT] = pabort_i;
    pend[C_SVC]  = svc_i;
    pend[C_UND]  = undef_i;
    active_raw   = reset_req_i | dabort_i | pabort_i | svc_i | undef_i
                 | (fast_int_i & ~fast_mask_i) | (norm_int_i & ~norm_mask_i);
  end

  trap_prio u_prio (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flush_i (busy),
    .pend_i  (pend),
    .win_o   (win),
    .clash_o (clash)
  );

  trap_issue #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_issue (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .win_i      (win),
    .clash_i    (clash),
    .ack_i      (ack_i),
    .take_nx_o  (take_nx),
    .busy_o     (busy),
    .take_o     (take_o),
    .vector_o   (vector_o),
    .cause_o    (cause_o),
    .conflict_o (conflict_o)
  );

  trap_lat_meter #(.LAT_W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idle_i   (~busy),
    .active_i (active_raw),
    .take_i   (take_nx),
    .lat_o    (latency_o)
  );

endmodule

// File: rtl/trap_select_unit_chk.sv
module trap_select_unit_chk
  import trap_pkg::*;
#(
  parameter int unsigned      VEC_W    = 32,
  parameter logic [VEC_W-1:0] VEC_BASE = '0,
  parameter int unsigned      LAT_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [NSRC-1:0]  cause_o,
  input logic             conflict_o,
  input logic [LAT_W-1:0] latency_o
);

  logic             waiting_q;
  logic [7:0]       exp_off;
  logic [VEC_W-1:0] exp_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
    end else if (take_o) begin
      waiting_q <= 1'b1;
    end else if (ack_i) begin
      waiting_q <= 1'b0;
    end
  end

  always_comb begin
    exp_off = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (cause_o[s]) begin
        exp_off = exp_off | src_offset(s);
      end
    end
    exp_vec = VEC_BASE + VEC_W'(exp_off);
  end

  p_vec_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vector_o == exp_vec);

  p_no_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vector_o != (VEC_BASE + VEC_W'(RSVD_OFF)));

  p_cause_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $countones(cause_o) == 1);

  p_conflict_und_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> (take_o && cause_o[C_UND]));

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  p_wait_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_q |-> !take_o);

  p_lat_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> latency_o >= LAT_W'(3));

endmodule

bind trap_select_unit trap_select_unit_chk #(
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .LAT_W    (LAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_i      (ack_i),
  .take_o     (take_o),
  .vector_o   (vector_o),
  .cause_o    (cause_o),
  .conflict_o (conflict_o),
  .latency_o  (latency_o)
);

// File: tb/trap_select_unit_tb.sv
module trap_select_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [6:0]  req;
  logic [1:0]  mask;
  logic        ack;
  logic        take;
  logic [31:0] vec;
  logic [6:0]  cause;
  logic        conflict;
  logic [7:0]  lat;

  int n_chk;
  int n_bad;

  trap_select_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_req_i (req[0]),
    .dabort_i    (req[1]),
    .fast_int_i  (req[2]),
    .norm_int_i  (req[3]),
    .pabort_i    (req[4]),
    .svc_i       (req[5]),
    .undef_i     (req[6]),
    .fast_mask_i (mask[0]),
    .norm_mask_i (mask[1]),
    .ack_i       (ack),
    .take_o      (take),
    .vector_o    (vec),
    .cause_o     (cause),
    .conflict_o  (conflict),
    .latency_o   (lat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // req bits: 0 reset, 1 dabort, 2 fast, 3 normal, 4 pabort, 5 svc, 6 undef
  typedef struct packed {
    logic [6:0] req;
    logic [1:0] mask;
    logic [6:0] cause;
    logic [7:0] off;
    logic       err;
    logic [3:0] cyc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{7'b0000001, 2'b00, 7'b0000001, 8'h00, 1'b0, 4'd3},
    '{7'b0000010, 2'b00, 7'b0000010, 8'h10, 1'b0, 4'd3},
    '{7'b0000100, 2'b00, 7'b0000100, 8'h1C, 1'b0, 4'd5},
    '{7'b0001000, 2'b00, 7'b0001000, 8'h18, 1'b0, 4'd5},
    '{7'b0010000, 2'b00, 7'b0010000, 8'h0C, 1'b0, 4'd3},
    '{7'b0100000, 2'b00, 7'b0100000, 8'h08, 1'b0, 4'd3},
    '{7'b1000000, 2'b00, 7'b1000000, 8'h04, 1'b0, 4'd3},
    '{7'b1111111, 2'b00, 7'b0000001, 8'h00, 1'b0, 4'd3},
    '{7'b0110010, 2'b00, 7'b0000010, 8'h10, 1'b0, 4'd3},
    '{7'b0001100, 2'b00, 7'b0000100, 8'h1C, 1'b0, 4'd5},
    '{7'b0001100, 2'b01, 7'b0001000, 8'h18, 1'b0, 4'd5},
    '{7'b1100000, 2'b00, 7'b1000000, 8'h04, 1'b1, 4'd3},
    '{7'b0001001, 2'b00, 7'b0000001, 8'h00, 1'b0, 4'd3},
    '{7'b0000110, 2'b00, 7'b0000010, 8'h10, 1'b0, 4'd3}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Wait for a strobe, returning how many negedges elapsed (0 = none).
  task automatic wait_take(input int limit, output int seen);
    seen = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (take) begin
        seen = i;
        break;
      end
    end
  endtask

  task automatic release_and_ack;
    req = '0;
    repeat (4) @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    report();
  end

  initial begin
    int seen;
    n_chk = 0;
    n_bad = 0;
    req   = '0;
    mask  = '0;
    ack   = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs in reset
    chk("R1", "take in reset", 32'(take), 0);
    chk("R1", "cause in reset", 32'(cause), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "take idle", 32'(take), 0);
    chk("R1", "cause idle", 32'(cause), 0);
    chk("R1", "vector idle", vec, 0);
    chk("R1", "conflict idle", 32'(conflict), 0);
    chk("R1", "latency idle", 32'(lat), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      req  = TBL[k].req;
      mask = TBL[k].mask;
      wait_take(12, seen);
      chk("R8", $sformatf("cycles v%0d", k), 32'(seen), 32'(TBL[k].cyc));
      chk("R4", $sformatf("cause v%0d", k), 32'(cause), 32'(TBL[k].cause));
      chk("R2", $sformatf("vector v%0d", k), vec, 32'(TBL[k].off));
      chk("R3", $sformatf("not reserved v%0d", k), 32'(vec == 32'h14), 0);
      chk("R6", $sformatf("conflict v%0d", k), 32'(conflict), 32'(TBL[k].err));
      chk("R10", $sformatf("latency v%0d", k), 32'(lat), 32'(TBL[k].cyc));
      req = '0;
      @(negedge clk);
      chk("R9", $sformatf("strobe width v%0d", k), 32'(take), 0);
      chk("R6", $sformatf("conflict width v%0d", k), 32'(conflict), 0);
      mask = '0;
      release_and_ack();
    end

    // R7: both interrupts masked, never taken
    mask = 2'b11;
    req  = 7'b0001100;
    wait_take(12, seen);
    chk("R7", "masked lines take", 32'(seen), 0);
    req = '0;
    repeat (4) @(negedge clk);
    mask = '0;
    repeat (2) @(negedge clk);

    // R8/R4: fast interrupt and prefetch abort in the same cycle
    req = 7'b0010100;
    wait_take(12, seen);
    chk("R8", "abort ahead of sync", 32'(seen), 3);
    chk("R4", "abort ahead of sync cause", 32'(cause), 32'h10);
    req = 7'b0000100;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    // R9: take on the fourth edge from the ack edge (3 negedges left)
    wait_take(10, seen);
    chk("R9", "ack to take", 32'(seen), 3);
    chk("R5", "fast after ack cause", 32'(cause), 32'h04);
    chk("R2", "fast after ack vector", vec, 32'h1C);
    chk("R10", "latency after ack", 32'(lat), 3);
    release_and_ack();

    // R9: held abort is not retaken before ack
    req = 7'b0000010;
    wait_take(12, seen);
    chk("R9", "first abort take", 32'(seen), 3);
    wait_take(10, seen);
    chk("R9", "no take without ack", 32'(seen), 0);
    chk("R10", "latency held", 32'(lat), 3);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    wait_take(10, seen);
    chk("R9", "retake after ack", 32'(seen), 3);
    chk("R4", "retake cause", 32'(cause), 32'h02);
    release_and_ack();

    // R1: asynchronous reset clears outputs at once
    req = 7'b0000001;
    wait_take(12, seen);
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "vector after async reset", vec, 0);
    chk("R1", "cause after async reset", 32'(cause), 0);
    chk("R1", "latency after async reset", 32'(lat), 0);
    req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report();
  end

endmodule